// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block drives the raster timing of a parallel TFT panel. A host writes a small bank of word registers holding the sync pulse widths, the line and frame totals, and the active window. The block then runs a horizontal pixel counter and a vertical line counter and derives horizontal sync, vertical sync and data enable from them. Each of the three has a programmable polarity. The counters advance only on cycles where the pixel strobe input is high. As a result, the outputs are qualified by the pixel rate while the logic runs on the system clock.

The active window is given as a start/end pair measured from the beginning of sync, in pixels for the horizontal axis and in lines for the vertical axis. Timing registers may be rewritten while the raster runs. The new values are copied into the working set only when a frame ends, so a frame never mixes old and new values. A stop request is held until the last pixel of the current frame. The counters then park at zero, every output returns to its inactive level, and a sticky halted flag is raised. The host clears that flag by writing zero to the status register.

Top module: `lcd_raster_gen`

## Requirements
- R1: After reset the block is idle. Both counters are zero, sync and enable outputs are low, the falling-edge select is low, and the active and halted flags are low.
- R2: The word register map is fixed:
  - Register 0 holds configuration.
  - Register 1 holds the horizontal sync width in bits [9:0]. Bits above bit 9 are ignored.
  - Register 2 holds the vertical sync width in the same form.
  - Register 3 packs the horizontal total in [31:16] and the vertical total in [15:0].
  - Register 4 packs the horizontal window start in [31:16] and end in [15:0].
  - Register 5 packs the vertical window start and end the same way.
  - Register 6 is control.
  - Register 7 is status.
- R3: While active, the pixel counter steps on each cycle with the pixel strobe high and wraps from total-1 to 0. The line counter steps when the pixel counter wraps and wraps from its own total-1 to 0. With the strobe low, both counters hold.
- R4: Horizontal sync is at its active level while the pixel counter is below the horizontal sync width. Vertical sync is at its active level while the line counter is below the vertical sync width.
- R5: Data enable is at its active level only when the pixel counter lies in [horizontal start, horizontal end) and the line counter lies in [vertical start, vertical end).
- R6: Configuration bit 11 makes horizontal sync active-low, bit 8 makes vertical sync active-low, and bit 9 makes data enable active-low. Bit 10 is passed out as the falling-edge select.
- R7: Timing and configuration writes made while active take effect from the first pixel of the next frame.
- R8: A control write with bit 4 set requests a stop. The frame in progress completes. After its last pixel the block goes idle, the counters read zero, the outputs sit at their inactive levels, and halted is set. A control write with bit 3 set and bit 4 clear starts an idle block at pixel 0, line 0.
- R9: A write to status with bit 0 clear clears halted. A write to status with bit 0 set leaves halted unchanged.
- R10: A stop request issued while idle sets halted on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_ce | input | 1 | Pixel strobe; counters advance only when high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word index |
| wr_data | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable, polarity applied |
| pclk_fall_o | output | 1 | Panel samples data on the falling pixel clock edge |
| h_pos_o | output | 16 | Current pixel counter |
| v_pos_o | output | 16 | Current line counter |
| active_o | output | 1 | Raster running |
| halted_o | output | 1 | Sticky stop-complete flag |

## Verification
A table of four timings is played back through whole frames. The timings differ in:
- line and frame length
- sync widths, including one with junk above bit 9 of the width register
- window placement
- polarity and edge settings: all high, sync low, enable low with falling edge, and everything low

Across them, the table separates errors in wrap points, window edges, sync compare width and polarity inversion. Each frame also carries an early stop request, which shows whether the stop waits for the frame end. Directed cases then:
- hold the pixel strobe low to show that the counters freeze;
- rewrite the sync width mid-frame, which distinguishes deferred loading from immediate loading;
- test clearing of the halted flag with both status values, and a stop request issued while idle.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;
   typedef enum logic [2:0] {
      RSEL_CFG  = 3'd0,
      RSEL_HSW  = 3'd1,
      RSEL_VSW  = 3'd2,
      RSEL_TOT  = 3'd3,
      RSEL_HWIN = 3'd4,
      RSEL_VWIN = 3'd5,
      RSEL_CTRL = 3'd6,
      RSEL_STAT = 3'd7
   } reg_sel_e;

   localparam int CFG_VS_LOW_BIT = 8;
   localparam int CFG_DE_LOW_BIT = 9;
   localparam int CFG_FALL_BIT   = 10;
   localparam int CFG_HS_LOW_BIT = 11;
   localparam int CTRL_RUN_BIT   = 3;
   localparam int CTRL_STOP_BIT  = 4;
   localparam int STAT_HALT_BIT  = 0;
endpackage

// File: rtl/lcd_timing_regs.sv
module lcd_timing_regs
   import lcd_raster_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   parameter int SYNC_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              load,
   output logic [SYNC_W-1:0] hsw,
   output logic [SYNC_W-1:0] vsw,
   output logic [CNT_W-1:0]  htot,
   output logic [CNT_W-1:0]  vtot,
   output logic [CNT_W-1:0]  hbeg,
   output logic [CNT_W-1:0]  hend,
   output logic [CNT_W-1:0]  vbeg,
   output logic [CNT_W-1:0]  vend,
   output logic [3:0]        pol,
   output logic              ctrl_wr,
   output logic              run_bit,
   output logic              stop_bit,
   output logic              stat_wr,
   output logic              stat_bit
);
   localparam int HALF = DATA_W / 2;
   localparam int VEC_W = 2 * SYNC_W + 6 * CNT_W + 4;

   logic [SYNC_W-1:0] h_hsw, h_vsw;
   logic [CNT_W-1:0]  h_htot, h_vtot, h_hbeg, h_hend, h_vbeg, h_vend;
   logic [3:0]        h_pol;
   logic [VEC_W-1:0]  host_vec, work_q;
   reg_sel_e          sel;

   assign sel = reg_sel_e'(wr_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_hsw  <= '0;
         h_vsw  <= '0;
         h_htot <= '0;
         h_vtot <= '0;
         h_hbeg <= '0;
         h_hend <= '0;
         h_vbeg <= '0;
         h_vend <= '0;
         h_pol  <= '0;
      end else if (wr_en) begin
         case (sel)
            RSEL_CFG:  h_pol <= {wr_data[CFG_HS_LOW_BIT], wr_data[CFG_FALL_BIT],
                                 wr_data[CFG_DE_LOW_BIT], wr_data[CFG_VS_LOW_BIT]};
            RSEL_HSW:  h_hsw <= wr_data[SYNC_W-1:0];
            RSEL_VSW:  h_vsw <= wr_data[SYNC_W-1:0];
            RSEL_TOT:  begin
               h_htot <= wr_data[HALF +: CNT_W];
               h_vtot <= wr_data[0 +: CNT_W];
            end
            RSEL_HWIN: begin
               h_hbeg <= wr_data[HALF +: CNT_W];
               h_hend <= wr_data[0 +: CNT_W];
            end
            RSEL_VWIN: begin
               h_vbeg <= wr_data[HALF +: CNT_W];
               h_vend <= wr_data[0 +: CNT_W];
            end
            default: ;
         endcase
      end
   end

   assign host_vec = {h_hsw, h_vsw, h_htot, h_vtot, h_hbeg, h_hend, h_vbeg, h_vend, h_pol};

   // working copy: follows the host set while idle, reloads only at frame end
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    work_q <= '0;
      else if (load) work_q <= host_vec;
   end

   assign {hsw, vsw, htot, vtot, hbeg, hend, vbeg, vend, pol} = work_q;

   assign ctrl_wr  = wr_en && (sel == RSEL_CTRL);
   assign run_bit  = wr_data[CTRL_RUN_BIT];
   assign stop_bit = wr_data[CTRL_STOP_BIT];
   assign stat_wr  = wr_en && (sel == RSEL_STAT);
   assign stat_bit = wr_data[STAT_HALT_BIT];

   logic unused_data;
   assign unused_data = ^wr_data;
endmodule

// File: rtl/lcd_axis_cnt.sv
module lcd_axis_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic [W-1:0] total,
   output logic [W-1:0] count,
   output logic         last
);
   logic [W:0] count_inc;

   assign count_inc = {1'b0, count} + 1'b1;
   assign last      = count_inc >= {1'b0, total};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (clr)  count <= '0;
      else if (step) count <= last ? '0 : count_inc[W-1:0];
   end

   assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && total != '0) |-> (count < total))
      else $error("counter beyond total");

   assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !step) |=> (count == $past(count)))
      else $error("counter moved without step");
endmodule

// File: rtl/lcd_run_ctrl.sv
module lcd_run_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic ctrl_wr,
   input  logic run_bit,
   input  logic stop_bit,
   input  logic stat_wr,
   input  logic stat_bit,
   input  logic frame_last,
   output logic running,
   output logic halted
);
   logic stop_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running   <= 1'b0;
         halted    <= 1'b0;
         stop_pend <= 1'b0;
      end else begin
         if (stat_wr && !stat_bit) halted <= 1'b0;
         if (ctrl_wr && stop_bit) begin
            if (running) stop_pend <= 1'b1;
            else         halted    <= 1'b1;
         end else if (ctrl_wr && run_bit && !running) begin
            running <= 1'b1;
         end
         if (running && frame_last && stop_pend) begin
            running   <= 1'b0;
            stop_pend <= 1'b0;
            halted    <= 1'b1;
         end
      end
   end

   assert_pend_needs_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pend |-> running)
      else $error("stop pending while idle");

   assert_stop_sets_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running) |-> halted)
      else $error("raster stopped without halted flag");

   assert_idle_stop_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && stop_bit && !running) |=> halted)
      else $error("idle stop request not flagged");
endmodule

// File: rtl/lcd_sync_out.sv
module lcd_sync_out #(
   parameter int CNT_W  = 16,
   parameter int SYNC_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              running,
   input  logic [CNT_W-1:0]  h,
   input  logic [CNT_W-1:0]  v,
   input  logic [SYNC_W-1:0] hsw,
   input  logic [SYNC_W-1:0] vsw,
   input  logic [CNT_W-1:0]  hbeg,
   input  logic [CNT_W-1:0]  hend,
   input  logic [CNT_W-1:0]  vbeg,
   input  logic [CNT_W-1:0]  vend,
   input  logic [2:0]        low,
   output logic [2:0]        lanes
);
   localparam int NLANE = 3;
   logic [NLANE-1:0] act;

   assign act[0] = {{(CNT_W-SYNC_W){1'b0}}, hsw} > h;
   assign act[1] = {{(CNT_W-SYNC_W){1'b0}}, vsw} > v;
   assign act[2] = (h >= hbeg) && (h < hend) && (v >= vbeg) && (v < vend);

   for (genvar i = 0; i < NLANE; i++) begin : g_lane
      assign lanes[i] = running ? (act[i] ^ low[i]) : low[i];
   end

   assert_vsync_on_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (running && $past(running) && (act[1] != $past(act[1]))) |-> (h == '0))
      else $error("vertical sync changed mid-line");
endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen
   import lcd_raster_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   parameter int SYNC_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_ce,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              hsync_o,
   output logic              vsync_o,
   output logic              de_o,
   output logic              pclk_fall_o,
   output logic [CNT_W-1:0]  h_pos_o,
   output logic [CNT_W-1:0]  v_pos_o,
   output logic              active_o,
   output logic              halted_o
);
   if (CNT_W > DATA_W / 2) begin : g_bad_cnt
      $error("CNT_W must fit half a data word");
   end
   if (SYNC_W > CNT_W) begin : g_bad_sync
      $error("SYNC_W must not exceed CNT_W");
   end

   logic [SYNC_W-1:0] hsw, vsw;
   logic [CNT_W-1:0]  htot, vtot, hbeg, hend, vbeg, vend;
   logic [3:0]        pol;
   logic ctrl_wr, run_bit, stop_bit, stat_wr, stat_bit;
   logic running, halted, h_last, v_last, h_step, frame_last, load;
   logic [2:0] lanes;

   assign h_step     = running && pix_ce;
   assign frame_last = h_step && h_last && v_last;
   assign load       = !running || frame_last;

   lcd_timing_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SYNC_W(SYNC_W)) u_regs (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .load,
      .hsw, .vsw, .htot, .vtot, .hbeg, .hend, .vbeg, .vend, .pol,
      .ctrl_wr, .run_bit, .stop_bit, .stat_wr, .stat_bit
   );

   lcd_run_ctrl u_ctrl (
      .clk, .rst_n, .ctrl_wr, .run_bit, .stop_bit, .stat_wr, .stat_bit,
      .frame_last, .running, .halted
   );

   lcd_axis_cnt #(.W(CNT_W)) u_hcnt (
      .clk, .rst_n, .clr(!running), .step(h_step), .total(htot),
      .count(h_pos_o), .last(h_last)
   );

   lcd_axis_cnt #(.W(CNT_W)) u_vcnt (
      .clk, .rst_n, .clr(!running), .step(h_step && h_last), .total(vtot),
      .count(v_pos_o), .last(v_last)
   );

   // pol = {hs_low, fall, de_low, vs_low}
   lcd_sync_out #(.CNT_W(CNT_W), .SYNC_W(SYNC_W)) u_out (
      .clk, .rst_n, .running, .h(h_pos_o), .v(v_pos_o),
      .hsw, .vsw, .hbeg, .hend, .vbeg, .vend,
      .low({pol[1], pol[0], pol[3]}), .lanes
   );

   assign hsync_o     = lanes[0];
   assign vsync_o     = lanes[1];
   assign de_o        = lanes[2];
   assign pclk_fall_o = pol[2];
   assign active_o    = running;
   assign halted_o    = halted;

   assert_frame_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> (h_pos_o == '0 && v_pos_o == '0))
      else $error("raster did not start at origin");
endmodule

// File: tb/test_lcd_raster_gen.sv
module test_lcd_raster_gen;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pix_ce = 1'b0;
   logic wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic hsync_o, vsync_o, de_o, pclk_fall_o, active_o, halted_o;
   logic [15:0] h_pos_o, v_pos_o;

   int n_chk = 0;
   int n_bad = 0;
   bit reported = 0;

   always #10 clk = ~clk;

   lcd_raster_gen i_lcd_raster_gen (
      .clk, .rst_n, .pix_ce, .wr_en, .wr_addr, .wr_data,
      .hsync_o, .vsync_o, .de_o, .pclk_fall_o,
      .h_pos_o, .v_pos_o, .active_o, .halted_o
   );

   // per row: cfg, hsync width, vsync width, totals, h window, v window
   localparam logic [31:0] VEC [4][6] = '{
      '{32'h0000_0000, 32'h0000_0002, 32'h0000_0001, 32'h000A_0006, 32'h0003_0008, 32'h0002_0005},
      '{32'h0000_0900, 32'h0000_0003, 32'h0000_0002, 32'h000C_0005, 32'h0004_000A, 32'h0002_0004},
      '{32'h0000_0600, 32'h0000_0001, 32'h0000_0001, 32'h0008_0004, 32'h0002_0007, 32'h0001_0003},
      '{32'h0000_0F00, 32'h0000_0402, 32'h0000_FC01, 32'h0009_0003, 32'h0002_0009, 32'h0001_0003}
   };

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      end
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic load_vec(input int i);
      for (int r = 0; r < 6; r++) reg_wr(r[2:0], VEC[i][r]);
   endtask

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      report();
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 h", 32'(h_pos_o), 0);
      chk("R1 v", 32'(v_pos_o), 0);
      chk("R1 outs", {28'd0, hsync_o, vsync_o, de_o, pclk_fall_o}, 0);
      chk("R1 flags", {30'd0, active_o, halted_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", {28'd0, hsync_o, vsync_o, de_o, active_o}, 0);

      // table walk: R2 R3 R4 R5 R6 R8 R9
      pix_ce = 1'b1;
      for (int i = 0; i < 4; i++) begin
         int hsw, vsw, ht, vt, hb, he, vb, ve, n;
         logic hl, vl, dl, fe;
         hsw = int'(VEC[i][1][9:0]);  vsw = int'(VEC[i][2][9:0]);
         ht  = int'(VEC[i][3][31:16]); vt = int'(VEC[i][3][15:0]);
         hb  = int'(VEC[i][4][31:16]); he = int'(VEC[i][4][15:0]);
         vb  = int'(VEC[i][5][31:16]); ve = int'(VEC[i][5][15:0]);
         hl = VEC[i][0][11]; vl = VEC[i][0][8]; dl = VEC[i][0][9]; fe = VEC[i][0][10];
         n = ht * vt;
         load_vec(i);
         reg_wr(3'd6, 32'h8);
         for (int k = 0; k <= n; k++) begin
            if (k < n) begin
               int eh, ev;
               logic ehs, evs, ede;
               eh = k % ht; ev = (k / ht) % vt;
               ehs = (eh < hsw) ^ hl;
               evs = (ev < vsw) ^ vl;
               ede = ((eh >= hb) && (eh < he) && (ev >= vb) && (ev < ve)) ^ dl;
               chk("R3 R4 R5 R6 raster",
                   {h_pos_o, v_pos_o[11:0], ehs ^ hsync_o ^ ehs, vsync_o, de_o, pclk_fall_o},
                   {eh[15:0], ev[11:0], ehs, evs, ede, fe});
               chk("R8 active during frame", 32'(active_o), 1);
            end else begin
               chk("R8 stopped at frame end",
                   {h_pos_o, v_pos_o[11:0], hsync_o, vsync_o, de_o, active_o},
                   {16'd0, 12'd0, hl, vl, dl, 1'b0});
               chk("R8 halted", 32'(halted_o), 1);
            end
            if (k == 3) begin
               wr_en = 1'b1; wr_addr = 3'd6; wr_data = 32'h10;
            end else begin
               wr_en = 1'b0;
            end
            @(negedge clk);
         end
         reg_wr(3'd7, 32'h1);
         chk("R9 status write of one keeps halted", 32'(halted_o), 1);
         reg_wr(3'd7, 32'h0);
         chk("R9 status write of zero clears", 32'(halted_o), 0);
      end

      // R3 hold with strobe low, R7 deferred timing update
      load_vec(0);
      pix_ce = 1'b0;
      reg_wr(3'd6, 32'h8);
      repeat (3) @(negedge clk);
      chk("R3 hold without strobe", {h_pos_o, v_pos_o}, 0);
      reg_wr(3'd1, 32'h5);
      pix_ce = 1'b1;
      for (int k = 0; k <= 63; k++) begin
         if (k == 3)  chk("R7 old width in current frame", {31'd0, hsync_o}, 0);
         if (k == 63) chk("R7 new width in next frame", {h_pos_o, 15'd0, hsync_o}, {16'd3, 15'd0, 1'b1});
         @(negedge clk);
      end
      reg_wr(3'd6, 32'h10);
      for (int w = 0; w < 200 && !halted_o; w++) @(negedge clk);
      chk("R8 stop completes", {30'd0, active_o, halted_o}, 32'h1);
      reg_wr(3'd7, 32'h0);

      // R10: stop while idle
      reg_wr(3'd6, 32'h10);
      chk("R10 idle stop flags halted", {30'd0, active_o, halted_o}, 32'h1);
      reg_wr(3'd7, 32'h0);
      chk("R10 cleared", 32'(halted_o), 0);

      report();
      $finish;
   end
endmodule